// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block chooses which pending interrupt of one small interrupt controller should go to the processor. It takes a request vector, a mask vector and an in-service vector. It applies a priority order that starts at a movable rotation offset, so the line at the offset has the highest priority and the line just below it, wrapping around, has the lowest. A request is raised only when it strictly outranks the highest-priority line that is still in service.

When the controller is the master of a cascaded pair and runs in special fully nested mode, the line that carries the cascade is left out of the in-service comparison. A second request from the slave can then pass through while an earlier one from the same slave is still being served.

A small register holds the rotation offset. It loads from a write port and keeps its value otherwise. The decision itself is computed in a single cycle. A parameter chooses whether the result is registered once before it reaches the outputs or passed straight through.

Top module: `rotating_priority_resolver`

## Requirements
- R1: While reset is held, and on the first edge after it, `int_valid` is 0. The rotation offset returns to 0 on reset.
- R2: A line whose mask bit is 1 never wins, even when its request bit is 1. Candidates are `req_pend & ~req_mask`.
- R3: When no candidate bit is set, `int_valid` is 0.
- R4: Priority index p refers to line (p + offset) mod LINES, and index 0 is the highest. The winner is the candidate with the lowest index, and `int_line` reports its line number (index + offset) mod LINES.
- R5: A request is signalled only if its index is strictly lower than the lowest index among the effective in-service bits. A request at equal or lower priority is blocked.
- R6: When no effective in-service bit is set, `int_valid` is 1 exactly when at least one candidate exists.
- R7: When `nested_master` is 1, in-service bit CASC_LINE (default 2) is ignored in the comparison, and all other in-service bits still block.
- R8: A cycle with `ofs_load` = 1 sets the offset to `ofs_value` from the next cycle on. With `ofs_load` = 0 the offset holds, whatever `ofs_value` is.
- R9: With OUT_REG = 1, the outputs show, one clock edge later, the decision for the inputs and offset that were present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_pend | input | LINES | Pending request bits, one per line |
| req_mask | input | LINES | Mask bits; 1 removes the line from the candidates |
| in_service | input | LINES | Lines currently in service |
| nested_master | input | 1 | Master in special fully nested mode; drops the cascade line from the in-service comparison |
| ofs_load | input | 1 | Loads `ofs_value` into the offset register |
| ofs_value | input | IDX_W | New rotation offset |
| int_valid | output | 1 | Interrupt should be raised |
| int_line | output | IDX_W | Winning line number; meaningless when `int_valid` is 0 |

## Verification
The bench builds the block with its defaults: eight lines, the cascade exclusion enabled on line 2, and a registered output. This brings every rotation offset, the wrap of the priority order past line 7, and the cascade exclusion into reach, along with the one-edge output latency. The vector table covers offsets 0, 3, 4, 6 and 7, masked winners, equal-priority blocking and the nested-mode exclusion of line 2. Directed tests cover reset, holding the offset while `ofs_value` changes, and the exact cycle in which the outputs change.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

   localparam int unsigned DEF_LINES     = 8;
   localparam int unsigned DEF_CASC_LINE = 2;

   // true when n is a power of two no smaller than two
   function automatic bit lines_ok(input int unsigned n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   // result of one priority search
   typedef struct packed {
      logic       none;
      logic [7:0] idx;
   } search_t;

endpackage

// File: rtl/rpr_find_first.sv
// Rotate a vector by the offset, then find the lowest set index.
module rpr_find_first #(
   parameter int unsigned LINES = rpr_pkg::DEF_LINES,
   localparam int unsigned IDX_W = $clog2(LINES)
) (
   input  logic [LINES-1:0] vec,
   input  logic [IDX_W-1:0] ofs,
   output logic [IDX_W-1:0] idx,
   output logic             none
);

   logic [LINES-1:0] rot;

   for (genvar p = 0; p < LINES; p++) begin : g_rot
      logic [IDX_W-1:0] phys;
      assign phys   = IDX_W'(p) + ofs;   // wraps mod LINES
      assign rot[p] = vec[phys];
   end

   always_comb begin
      idx = '0;
      for (int p = LINES - 1; p >= 0; p--) begin
         if (rot[p]) idx = IDX_W'(p);
      end
   end

   assign none = (rot == '0);

endmodule

// File: rtl/rpr_select.sv
// Combinational arbitration between candidates and in-service level.
module rpr_select #(
   parameter int unsigned LINES     = rpr_pkg::DEF_LINES,
   parameter bit          CASC_EN   = 1'b1,
   parameter int unsigned CASC_LINE = rpr_pkg::DEF_CASC_LINE,
   localparam int unsigned IDX_W = $clog2(LINES)
) (
   input  logic [LINES-1:0] req_pend,
   input  logic [LINES-1:0] req_mask,
   input  logic [LINES-1:0] in_service,
   input  logic             nested_master,
   input  logic [IDX_W-1:0] ofs,
   output logic             sel_valid,
   output logic [IDX_W-1:0] sel_line
);

   logic [LINES-1:0] cand;
   logic [LINES-1:0] isr_eff;
   logic [IDX_W-1:0] req_idx, isr_idx;
   logic             req_none, isr_none;

   assign cand = req_pend & ~req_mask;

   if (CASC_EN) begin : g_casc
      logic [LINES-1:0] drop;
      assign drop    = nested_master ? (LINES'(1) << CASC_LINE) : '0;
      assign isr_eff = in_service & ~drop;
   end else begin : g_nocasc
      assign isr_eff = in_service;
   end

   rpr_find_first #(.LINES(LINES)) u_req (
      .vec (cand),
      .ofs (ofs),
      .idx (req_idx),
      .none(req_none)
   );

   rpr_find_first #(.LINES(LINES)) u_isr (
      .vec (isr_eff),
      .ofs (ofs),
      .idx (isr_idx),
      .none(isr_none)
   );

   assign sel_valid = !req_none && (isr_none || (req_idx < isr_idx));
   assign sel_line  = req_idx + ofs;

endmodule

// File: rtl/rpr_offset_reg.sv
// Holds the rotation offset; loads from a write port.
module rpr_offset_reg #(
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ofs_load,
   input  logic [IDX_W-1:0] ofs_value,
   output logic [IDX_W-1:0] ofs_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)        ofs_q <= '0;
      else if (ofs_load) ofs_q <= ofs_value;
   end

   assert_ofs_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_load |=> ofs_q == $past(ofs_value));

   assert_ofs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ofs_load |=> $stable(ofs_q));

   assert_ofs_reset_R1: assert property (@(posedge clk)
      !rst_n |=> ofs_q == '0);

endmodule

// File: rtl/rotating_priority_resolver.sv
module rotating_priority_resolver #(
   parameter int unsigned LINES     = rpr_pkg::DEF_LINES,
   parameter bit          CASC_EN   = 1'b1,
   parameter int unsigned CASC_LINE = rpr_pkg::DEF_CASC_LINE,
   parameter bit          OUT_REG   = 1'b1,
   localparam int unsigned IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] req_pend,
   input  logic [LINES-1:0] req_mask,
   input  logic [LINES-1:0] in_service,
   input  logic             nested_master,
   input  logic             ofs_load,
   input  logic [IDX_W-1:0] ofs_value,
   output logic             int_valid,
   output logic [IDX_W-1:0] int_line
);

   if (!rpr_pkg::lines_ok(LINES)) begin : g_bad_lines
      $error("LINES must be a power of two and at least 2");
   end
   if (CASC_EN && (CASC_LINE >= LINES)) begin : g_bad_casc
      $error("CASC_LINE must name an existing line");
   end

   logic [IDX_W-1:0] ofs_q;
   logic             sel_valid;
   logic [IDX_W-1:0] sel_line;

   rpr_offset_reg #(.IDX_W(IDX_W)) u_ofs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ofs_load (ofs_load),
      .ofs_value(ofs_value),
      .ofs_q    (ofs_q)
   );

   rpr_select #(
      .LINES    (LINES),
      .CASC_EN  (CASC_EN),
      .CASC_LINE(CASC_LINE)
   ) u_sel (
      .req_pend     (req_pend),
      .req_mask     (req_mask),
      .in_service   (in_service),
      .nested_master(nested_master),
      .ofs          (ofs_q),
      .sel_valid    (sel_valid),
      .sel_line     (sel_line)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            int_valid <= 1'b0;
            int_line  <= '0;
         end else begin
            int_valid <= sel_valid;
            int_line  <= sel_line;
         end
      end

      assert_reset_quiet_R1: assert property (@(posedge clk)
         !rst_n |=> !int_valid);
   end else begin : g_comb
      assign int_valid = sel_valid;
      assign int_line  = sel_line;
   end

   // effective in-service set as seen by the comparison
   logic [LINES-1:0] chk_drop;
   assign chk_drop = (CASC_EN && nested_master) ? (LINES'(1) << CASC_LINE) : '0;

   assert_winner_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> (req_pend[sel_line] && !req_mask[sel_line]));

   assert_idle_no_cand_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_pend & ~req_mask) == '0) |-> !sel_valid);

   assert_strict_above_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> !(in_service[sel_line] && !chk_drop[sel_line]));

   assert_free_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((in_service & ~chk_drop) == '0) |-> (sel_valid == ((req_pend & ~req_mask) != '0)));

   if (CASC_EN) begin : g_casc_chk
      assert_cascade_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (nested_master && in_service == (LINES'(1) << CASC_LINE)
          && ((req_pend & ~req_mask) != '0)) |-> sel_valid);
   end

endmodule

// File: tb/sim_rotating_priority_resolver.sv
module sim_rotating_priority_resolver;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] req_pend, req_mask, in_service;
   logic       nested_master, ofs_load;
   logic [2:0] ofs_value;
   logic       int_valid;
   logic [2:0] int_line;

   int n_checks = 0;
   int n_errors = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   rotating_priority_resolver u0 (
      .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .req_mask(req_mask),
      .in_service(in_service), .nested_master(nested_master),
      .ofs_load(ofs_load), .ofs_value(ofs_value),
      .int_valid(int_valid), .int_line(int_line)
   );

   // {pend[31:24], mask[23:16], isr[15:8], nested[7], ofs[6:4], exp_valid[3], exp_line[2:0]}
   localparam int NV = 14;
   localparam logic [31:0] VEC [NV] = '{
      32'h00000000,  // R3 nothing pending
      32'h2800000B,  // R4 offset 0 -> line 3
      32'h2800004D,  // R4 offset 4 -> line 5
      32'h2820004B,  // R2 line 5 masked -> line 3 after wrap
      32'hFFFF0000,  // R2 all masked
      32'h10000400,  // R5 line 4 below in-service line 2
      32'h02000409,  // R5 line 1 above in-service line 2
      32'h04000400,  // R5 equal priority blocked
      32'h1000048C,  // R7 cascade in-service ignored
      32'h10000580,  // R7 only cascade bit ignored
      32'h4100016E,  // R4 offset 6, line 6 beats in-service 0
      32'h01004060,  // R5 offset 6, in-service 6 blocks line 0
      32'h8000007F,  // R4 offset 7 -> line 7
      32'h04000230   // R5 offset 3, line 2 lowest, blocked by line 1
   };

   task automatic chk(input string req, input int val_act, input int val_exp);
      n_checks++;
      if (val_act !== val_exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, val_act, val_exp);
      end
   endtask

   task automatic idle_inputs();
      req_pend = '0; req_mask = '0; in_service = '0;
      nested_master = 1'b0; ofs_load = 1'b0; ofs_value = '0;
   endtask

   initial begin
      rst_n = 1'b0;
      idle_inputs();
      req_pend = 8'hFF;
      repeat (3) @(negedge clk);
      chk("R1 valid low in reset", int_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // offset is 0 after reset: all lines pending picks line 0
      chk("R1 valid after reset", int_valid, 1);
      chk("R1 offset zero after reset", int_line, 0);

      for (int i = 0; i < NV; i++) begin
         logic [31:0] v;
         v = VEC[i];
         @(negedge clk);
         req_pend = v[31:24]; req_mask = v[23:16]; in_service = v[15:8];
         nested_master = v[7]; ofs_load = 1'b1; ofs_value = v[6:4];
         @(negedge clk);
         ofs_load = 1'b0;
         @(negedge clk);
         chk($sformatf("R2 R3 R4 R5 R7 vector %0d valid", i), int_valid, int'(v[3]));
         if (v[3]) chk($sformatf("R4 vector %0d line", i), int_line, int'(v[2:0]));
      end

      // R8: offset holds while ofs_value changes without load
      @(negedge clk);
      idle_inputs();
      ofs_load = 1'b1; ofs_value = 3'd5;
      @(negedge clk);
      ofs_load = 1'b0; ofs_value = 3'd2; req_pend = 8'hFF;
      @(negedge clk);
      chk("R8 loaded offset used", int_line, 5);
      @(negedge clk);
      chk("R8 offset held without load", int_line, 5);

      // R9: output changes only after the next edge
      req_pend = 8'h01;          // offset 5: line 0 is index 3
      #1;
      chk("R9 output unchanged before edge", int_line, 5);
      @(negedge clk);
      chk("R9 output after one edge", int_line, 0);

      // R6: no in-service, one unmasked request wins regardless of position
      req_pend = 8'h10; req_mask = 8'h00;
      @(negedge clk);
      chk("R6 lone request valid", int_valid, 1);
      chk("R6 lone request line", int_line, 4);

      // R1: reset mid-run clears output and offset
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 valid cleared by reset", int_valid, 0);
      rst_n = 1'b1; req_pend = 8'hFF;
      @(negedge clk);
      chk("R1 offset cleared by reset", int_line, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule